// File: doc/BRIEF.md
# Prefix Hash Insertion Controller

This block loads IP prefix rules into hashed slot tables while a classifier is being configured. Each incoming rule carries a 32-bit prefix, a prefix length and a rule identifier. The prefix is first cut down to its length. The length then selects a bank: every length shorter than the hash width shares bank 0, and lengths 16, 24 and 32 each have a bank of their own. The masked prefix is hashed to a 9-bit address in that bank, and the rule identifier is written there.

If the primary address is already taken, a second hash function picks an alternative address. If that one is taken as well, the rule is parked in a small pending queue. A done strobe ends configuration. A drain pass then walks the queue in arrival order. For each parked rule it scans the occupancy of the rule's bank from address 0 upward and writes the rule into the first free slot. A read-back port exposes every slot so that the stored layout can be inspected.

The controller FSM has four states. CONFIG accepts one rule per cycle. PICK takes the head of the pending queue. SCAN tests one address per cycle. DONE is final until reset. Its transitions are:
- reset → CONFIG
- CONFIG → PICK on the done strobe
- PICK → SCAN when the queue is non-empty
- PICK → DONE when the queue is empty
- SCAN → PICK when a free slot is written, or when the last address is reached without finding one
- DONE → DONE

Top module: `prefix_hash_inserter`

## Requirements
- R1: After reset, `busy` and `err` are 0 and every slot of every bank reads back as empty (`rd_valid` = 0).
- R2: Rule length selects the bank as follows: lengths 0 to 8 go to bank 0, 16 to bank 1, 24 to bank 2 and 32 to bank 3. Any other length sets `err` and the rule is dropped.
- R3: The prefix is ANDed with a mask of `len` ones counted from bit 31, so bits beyond the length have no effect. The primary address is the XOR fold of the masked prefix, where masked bit i is XORed into address bit (i mod 9). A rule whose primary slot is free is stored there.
- R4: When the primary slot is taken, the secondary address is used. It is a 9-bit CRC computed over the masked prefix. The register starts at 0 and bits are fed from bit 31 down to bit 0. At each step the feedback is the register MSB XOR the data bit. The register shifts left by one, and when the feedback is 1 it is XORed with 0x11D.
- R5: When both slots are taken, the rule is queued. After the done strobe, queued rules are placed in arrival order, each at the lowest free address of its own bank.
- R6: `busy` rises on the cycle after the first rule whose primary slot was taken. It stays high until the drain pass finishes, and it is 0 in DONE.
- R7: The pending queue holds 8 rules. A ninth rule that needs queueing sets `err` and is dropped. `err` stays set until reset.
- R8: A queued rule whose bank has no free slot during the drain sets `err` and is dropped.
- R9: Rules presented after the done strobe are ignored.
- R10: The read-back port returns the valid bit and rule identifier of slot (`rd_bank`, `rd_addr`) one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rule_valid | input | 1 | A rule is presented this cycle |
| rule_prefix | input | 32 | Rule prefix, MSB first |
| rule_len | input | 6 | Prefix length in bits |
| rule_id | input | ID_W (8) | Identifier stored in the slot |
| cfg_done | input | 1 | Strobe: configuration finished, start drain |
| busy | output | 1 | Collision handling pending or drain in progress |
| err | output | 1 | Sticky error: bad length, queue overflow or bank full |
| rd_bank | input | 2 | Read-back bank select |
| rd_addr | input | H (9) | Read-back slot address |
| rd_valid | output | 1 | Selected slot is occupied |
| rd_id | output | ID_W (8) | Identifier in the selected slot |

## Verification
The hardest condition to reach from the ports is a drain with no free slot in the target bank. Random prefixes almost never fill all 512 addresses of a bank. The bench therefore builds one prefix per address: it places the address value in prefix bits 26:18 and leaves all other bits 0, so that each prefix's primary fold lands on exactly its own slot. After that fill, every further rule for the bank collides on both hashes. This drives both the queue-overflow boundary (8 fits, the ninth errors) and the bank-full drain error.

// File: rtl/prefix_ins_pkg.sv
`timescale 1ns/1ps
package prefix_ins_pkg;
    typedef enum logic [1:0] {
        S_CONFIG = 2'd0,
        S_PICK   = 2'd1,
        S_SCAN   = 2'd2,
        S_DONE   = 2'd3
    } ins_state_t;

    localparam int PFX_W = 32;
    localparam int LEN_W = 6;
endpackage

// File: rtl/prefix_hash_unit.sv
`timescale 1ns/1ps
module prefix_hash_unit
    import prefix_ins_pkg::*;
#(
    parameter int             H      = 9,
    parameter logic [H-1:0]   POLY   = 9'h11D,
    parameter int             LEN_B1 = 16,
    parameter int             LEN_B2 = 24,
    parameter int             LEN_B3 = 32
) (
    input  logic [PFX_W-1:0] prefix,
    input  logic [LEN_W-1:0] len,
    output logic [1:0]       bank,
    output logic             len_ok,
    output logic [H-1:0]     h_pri,
    output logic [H-1:0]     h_alt
);
    logic [PFX_W-1:0] mask;
    logic [PFX_W-1:0] masked;
    logic [H-1:0]     crc;
    logic             fb;

    // Keep only the top 'len' bits of the prefix.
    always_comb begin
        if (len == '0) mask = '0;
        else           mask = {PFX_W{1'b1}} << (LEN_W'(PFX_W) - len);
        masked = prefix & mask;
    end

    // Primary: XOR fold, bit i lands on bit (i mod H).
    always_comb begin
        h_pri = '0;
        for (int i = 0; i < PFX_W; i++) begin
            h_pri[i % H] = h_pri[i % H] ^ masked[i];
        end
    end

    // Secondary: serial CRC, MSB of the prefix first.
    always_comb begin
        crc = '0;
        fb  = 1'b0;
        for (int i = PFX_W - 1; i >= 0; i--) begin
            fb  = crc[H-1] ^ masked[i];
            crc = {crc[H-2:0], 1'b0};
            if (fb) crc = crc ^ POLY;
        end
        h_alt = crc;
    end

    // Bank selection by length class.
    always_comb begin
        bank   = 2'd0;
        len_ok = 1'b1;
        if (len < LEN_W'(H))              bank = 2'd0;
        else if (len == LEN_W'(LEN_B1))   bank = 2'd1;
        else if (len == LEN_W'(LEN_B2))   bank = 2'd2;
        else if (len == LEN_W'(LEN_B3))   bank = 2'd3;
        else                              len_ok = 1'b0;
    end
endmodule

// File: rtl/slot_table.sv
`timescale 1ns/1ps
module slot_table #(
    parameter int H       = 9,
    parameter int ID_W    = 8,
    parameter int N_BANKS = 4,
    localparam int DEPTH  = 1 << H,
    localparam int BANK_W = $clog2(N_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pa_bank,
    input  logic [H-1:0]      pa_addr,
    output logic              pa_occ,
    input  logic [BANK_W-1:0] pb_bank,
    input  logic [H-1:0]      pb_addr,
    output logic              pb_occ,
    input  logic              we,
    input  logic [BANK_W-1:0] w_bank,
    input  logic [H-1:0]      w_addr,
    input  logic [ID_W-1:0]   w_id,
    input  logic [BANK_W-1:0] rb_bank,
    input  logic [H-1:0]      rb_addr,
    output logic              rb_valid,
    output logic [ID_W-1:0]   rb_id
);
    logic [DEPTH-1:0] occ [N_BANKS];
    logic [ID_W-1:0]  ids [N_BANKS][DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BANKS; b++) occ[b] <= '0;
        end else if (we) begin
            occ[w_bank][w_addr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) ids[w_bank][w_addr] <= w_id;
    end

    assign pa_occ = occ[pa_bank][pa_addr];
    assign pb_occ = occ[pb_bank][pb_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_valid <= 1'b0;
            rb_id    <= '0;
        end else begin
            rb_valid <= occ[rb_bank][rb_addr];
            rb_id    <= ids[rb_bank][rb_addr];
        end
    end
endmodule

// File: rtl/pend_fifo.sv
`timescale 1ns/1ps
module pend_fifo #(
    parameter int  DEPTH  = 8,
    parameter int  W      = 10,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full) wr_ptr <= bump(wr_ptr);
            if (pop && !empty) rd_ptr <= bump(rd_ptr);
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) slots[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/prefix_hash_inserter.sv
`timescale 1ns/1ps
module prefix_hash_inserter
    import prefix_ins_pkg::*;
#(
    parameter int           H          = 9,
    parameter int           ID_W       = 8,
    parameter int           PEND_DEPTH = 8,
    parameter logic [H-1:0] POLY       = 9'h11D,
    parameter int           LEN_B1     = 16,
    parameter int           LEN_B2     = 24,
    parameter int           LEN_B3     = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rule_valid,
    input  logic [31:0]     rule_prefix,
    input  logic [5:0]      rule_len,
    input  logic [ID_W-1:0] rule_id,
    input  logic            cfg_done,
    output logic            busy,
    output logic            err,
    input  logic [1:0]      rd_bank,
    input  logic [H-1:0]    rd_addr,
    output logic            rd_valid,
    output logic [ID_W-1:0] rd_id
);
    localparam int N_BANKS = 4;
    localparam int BANK_W  = 2;
    localparam int PEND_W  = BANK_W + ID_W;
    localparam int CNT_W   = $clog2(PEND_DEPTH + 1);

    ins_state_t state_q, state_d;

    logic [BANK_W-1:0] h_bank;
    logic              len_ok;
    logic [H-1:0]      h_pri, h_alt;

    logic [BANK_W-1:0] pa_bank;
    logic [H-1:0]      pa_addr;
    logic              pa_occ, pb_occ;

    logic              tbl_we;
    logic [BANK_W-1:0] w_bank;
    logic [H-1:0]      w_addr;
    logic [ID_W-1:0]   w_id;

    logic              push, pop;
    logic [PEND_W-1:0] pend_head;
    logic [CNT_W-1:0]  pend_count;
    logic              pend_full, pend_empty;
    logic [BANK_W-1:0] head_bank;
    logic [ID_W-1:0]   head_id;

    logic [H-1:0]      scan_addr;
    logic              scan_clr, scan_inc;
    logic              err_set, coll;
    logic              busy_q, err_q;

    assign head_bank = pend_head[PEND_W-1 -: BANK_W];
    assign head_id   = pend_head[ID_W-1:0];

    prefix_hash_unit #(
        .H(H), .POLY(POLY), .LEN_B1(LEN_B1), .LEN_B2(LEN_B2), .LEN_B3(LEN_B3)
    ) u_hash (
        .prefix (rule_prefix),
        .len    (rule_len),
        .bank   (h_bank),
        .len_ok (len_ok),
        .h_pri  (h_pri),
        .h_alt  (h_alt)
    );

    // Port A serves the primary probe in CONFIG and the scan probe in SCAN.
    assign pa_bank = (state_q == S_SCAN) ? head_bank : h_bank;
    assign pa_addr = (state_q == S_SCAN) ? scan_addr : h_pri;

    slot_table #(.H(H), .ID_W(ID_W), .N_BANKS(N_BANKS)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .pa_bank  (pa_bank),
        .pa_addr  (pa_addr),
        .pa_occ   (pa_occ),
        .pb_bank  (h_bank),
        .pb_addr  (h_alt),
        .pb_occ   (pb_occ),
        .we       (tbl_we),
        .w_bank   (w_bank),
        .w_addr   (w_addr),
        .w_id     (w_id),
        .rb_bank  (rd_bank),
        .rb_addr  (rd_addr),
        .rb_valid (rd_valid),
        .rb_id    (rd_id)
    );

    pend_fifo #(.DEPTH(PEND_DEPTH), .W(PEND_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({h_bank, rule_id}),
        .pop       (pop),
        .head      (pend_head),
        .count     (pend_count),
        .full      (pend_full),
        .empty     (pend_empty)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_CONFIG;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CONFIG: if (cfg_done) state_d = S_PICK;
            S_PICK:   state_d = pend_empty ? S_DONE : S_SCAN;
            S_SCAN:   if (!pa_occ || scan_addr == '1) state_d = S_PICK;
            S_DONE:   state_d = S_DONE;
        endcase
    end

    // Per-state outputs
    always_comb begin
        tbl_we   = 1'b0;
        w_bank   = h_bank;
        w_addr   = h_pri;
        w_id     = rule_id;
        push     = 1'b0;
        pop      = 1'b0;
        err_set  = 1'b0;
        coll     = 1'b0;
        scan_clr = 1'b0;
        scan_inc = 1'b0;
        unique case (state_q)
            S_CONFIG: begin
                if (rule_valid) begin
                    if (!len_ok) begin
                        err_set = 1'b1;
                    end else if (!pa_occ) begin
                        tbl_we = 1'b1;
                    end else begin
                        coll = 1'b1;
                        if (!pb_occ) begin
                            tbl_we = 1'b1;
                            w_addr = h_alt;
                        end else if (!pend_full) begin
                            push = 1'b1;
                        end else begin
                            err_set = 1'b1;
                        end
                    end
                end
            end
            S_PICK: begin
                scan_clr = 1'b1;
            end
            S_SCAN: begin
                w_bank = head_bank;
                w_addr = scan_addr;
                w_id   = head_id;
                if (!pa_occ) begin
                    tbl_we = 1'b1;
                    pop    = 1'b1;
                end else if (scan_addr == '1) begin
                    err_set = 1'b1;
                    pop     = 1'b1;
                end else begin
                    scan_inc = 1'b1;
                end
            end
            S_DONE: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_addr <= '0;
            busy_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (scan_clr)      scan_addr <= '0;
            else if (scan_inc) scan_addr <= scan_addr + 1'b1;

            if (state_d == S_DONE) busy_q <= 1'b0;
            else if (coll)         busy_q <= 1'b1;

            if (err_set) err_q <= 1'b1;
        end
    end

    assign busy = busy_q;
    assign err  = err_q;
endmodule

// File: rtl/prefix_hash_inserter_chk.sv
`timescale 1ns/1ps
module prefix_hash_inserter_chk
    import prefix_ins_pkg::*;
#(
    parameter int  PEND_DEPTH = 8,
    localparam int CNT_W      = $clog2(PEND_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input ins_state_t       state,
    input logic             busy,
    input logic             err,
    input logic             tbl_we,
    input logic [CNT_W-1:0] pend_count
);
    // R6: busy is low once the drain pass has finished
    assert_idle_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |-> !busy);

    // R7: error flag is sticky
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R7: queue never exceeds its depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_count <= CNT_W'(PEND_DEPTH));

    // R9: no table writes and no exit once configuration is closed
    assert_frozen_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |-> (!tbl_we ##1 state == S_DONE));

    // R5: each drain placement removes exactly one queued rule
    assert_drain_pops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SCAN && tbl_we) |=> (pend_count == $past(pend_count) - 1'b1));

    // R6: drain states only entered after the done strobe left CONFIG
    assert_no_return_config_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_CONFIG) |=> (state != S_CONFIG));
endmodule

bind prefix_hash_inserter prefix_hash_inserter_chk #(.PEND_DEPTH(PEND_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .busy       (busy),
    .err        (err),
    .tbl_we     (tbl_we),
    .pend_count (pend_count)
);

// File: tb/test_prefix_hash_inserter.sv
`timescale 1ns/1ps
module test_prefix_hash_inserter;
    localparam int H    = 9;
    localparam int ID_W = 8;
    localparam int DEPTH = 1 << H;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rule_valid = 1'b0;
    logic [31:0]     rule_prefix = '0;
    logic [5:0]      rule_len = '0;
    logic [ID_W-1:0] rule_id = '0;
    logic            cfg_done = 1'b0;
    logic            busy, err;
    logic [1:0]      rd_bank = '0;
    logic [H-1:0]    rd_addr = '0;
    logic            rd_valid;
    logic [ID_W-1:0] rd_id;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    bit m_occ [4][DEPTH];
    int m_id  [4][DEPTH];
    int q_bank [$];
    int q_id   [$];
    bit m_err;
    bit m_coll;

    always #2 clk = ~clk;

    prefix_hash_inserter i_prefix_hash_inserter (
        .clk(clk), .rst_n(rst_n), .rule_valid(rule_valid), .rule_prefix(rule_prefix),
        .rule_len(rule_len), .rule_id(rule_id), .cfg_done(cfg_done), .busy(busy),
        .err(err), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_id(rd_id)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference functions written from R2, R3, R4
    function automatic logic [31:0] f_mask(input logic [31:0] p, input int len);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < len && i < 32; i++) m[31 - i] = 1'b1;
        return p & m;
    endfunction

    function automatic logic [8:0] f_h1(input logic [31:0] mp);
        logic [8:0] h;
        h = '0;
        for (int i = 0; i < 32; i++) h[i % 9] ^= mp[i];
        return h;
    endfunction

    function automatic logic [8:0] f_h2(input logic [31:0] mp);
        logic [8:0] c;
        logic f;
        c = '0;
        for (int i = 31; i >= 0; i--) begin
            f = c[8] ^ mp[i];
            c = {c[7:0], 1'b0};
            if (f) c ^= 9'h11D;
        end
        return c;
    endfunction

    function automatic int f_bank(input int len);
        if (len <= 8)  return 0;
        if (len == 16) return 1;
        if (len == 24) return 2;
        if (len == 32) return 3;
        return -1;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < DEPTH; a++) begin
                m_occ[b][a] = 1'b0;
                m_id[b][a] = 0;
            end
        q_bank.delete();
        q_id.delete();
        m_err = 1'b0;
        m_coll = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rule_valid = 1'b0;
        cfg_done = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic model_rule(input logic [31:0] p, input int len, input int id);
        int b;
        logic [31:0] mp;
        logic [8:0] a1, a2;
        b = f_bank(len);
        if (b < 0) begin
            m_err = 1'b1;
            return;
        end
        mp = f_mask(p, len);
        a1 = f_h1(mp);
        a2 = f_h2(mp);
        if (!m_occ[b][a1]) begin
            m_occ[b][a1] = 1'b1; m_id[b][a1] = id;
        end else begin
            m_coll = 1'b1;
            if (!m_occ[b][a2]) begin
                m_occ[b][a2] = 1'b1; m_id[b][a2] = id;
            end else if (q_bank.size() < 8) begin
                q_bank.push_back(b); q_id.push_back(id);
            end else begin
                m_err = 1'b1;
            end
        end
    endtask

    // Called at a negedge; rule captured at the next posedge.
    task automatic send_rule(input logic [31:0] p, input int len, input int id, input bit accepted);
        rule_valid = 1'b1;
        rule_prefix = p;
        rule_len = 6'(len);
        rule_id = ID_W'(id);
        @(negedge clk);
        rule_valid = 1'b0;
        if (accepted) model_rule(p, len, id);
    endtask

    task automatic model_drain();
        while (q_bank.size() > 0) begin
            int b, id;
            bit placed;
            b = q_bank.pop_front();
            id = q_id.pop_front();
            placed = 1'b0;
            for (int a = 0; a < DEPTH && !placed; a++)
                if (!m_occ[b][a]) begin
                    m_occ[b][a] = 1'b1; m_id[b][a] = id; placed = 1'b1;
                end
            if (!placed) m_err = 1'b1;
        end
    endtask

    task automatic close_cfg();
        bit seen_low;
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        model_drain();
        seen_low = 1'b0;
        for (int k = 0; k < 6000 && !seen_low; k++) begin
            @(negedge clk);
            if (!busy) seen_low = 1'b1;
        end
        chk(seen_low, "R6 busy falls after drain", busy, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        for (int b = 0; b < 4; b++)
            for (int a = 0; a < DEPTH; a++) begin
                rd_bank = 2'(b);
                rd_addr = H'(a);
                @(negedge clk);
                chk(rd_valid == m_occ[b][a], {tag, " R10 slot valid"}, rd_valid, m_occ[b][a]);
                if (m_occ[b][a])
                    chk(rd_id == ID_W'(m_id[b][a]), {tag, " R10 slot id"}, rd_id, m_id[b][a]);
            end
    endtask

    task automatic fill_bank1();
        for (int a = 0; a < DEPTH; a++)
            send_rule({5'b0, 9'(a), 18'b0}, 16, a & 8'hFF, 1'b1);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                chk(1'b0, "watchdog", cycles, 190000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd4711);

        // ---------- Episode 1: reset state (R1)
        do_reset();
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(err == 1'b0, "R1 err after reset", err, 0);
        check_all("R1 empty");

        // ---------- Episode 2: directed and random insertion
        do_reset();
        send_rule(32'hC0A8_0100, 24, 1, 1'b1);
        chk(busy == 1'b0, "R3 no busy without collision", busy, 0);
        // differs only beyond the length: same slot, takes hash 2
        send_rule(32'hC0A8_01FF, 24, 2, 1'b1);
        chk(busy == 1'b1, "R6 busy after first collision", busy, 1);
        send_rule(32'hC0A8_0177, 24, 3, 1'b1);   // R5 queued
        rd_bank = 2'd2;
        rd_addr = f_h1(f_mask(32'hC0A8_0100, 24));
        @(negedge clk);
        chk(rd_valid && rd_id == 8'd1, "R3 primary slot holds id 1", rd_id, 1);
        rd_addr = f_h2(f_mask(32'hC0A8_0100, 24));
        @(negedge clk);
        chk(rd_valid && rd_id == 8'd2, "R4 secondary slot holds id 2", rd_id, 2);
        // short prefixes share bank 0; len 0 masks everything
        send_rule(32'hDEAD_BEEF, 0, 10, 1'b1);
        send_rule(32'h1234_5678, 0, 11, 1'b1);
        send_rule(32'hAB00_0000, 8, 12, 1'b1);
        send_rule(32'hFFFF_FFFF, 32, 13, 1'b1);
        chk(err == 1'b0, "R2 no err for legal lengths", err, 0);
        for (int k = 0; k < 150; k++) begin
            int sel, len;
            sel = $urandom_range(0, 9);
            len = (sel < 2) ? $urandom_range(0, 8) : (sel < 5) ? 16 : (sel < 8) ? 24 : 32;
            send_rule($urandom, len, 20 + k, 1'b1);
        end
        chk(err == m_err, "R7 err matches queue model", err, m_err);
        send_rule(32'h0A00_0000, 20, 99, 1'b1);
        chk(err == 1'b1, "R2 unsupported length sets err", err, 1);
        close_cfg();
        send_rule(32'h0102_0304, 32, 200, 1'b0);   // R9 ignored
        chk(busy == 1'b0, "R6 busy low in done", busy, 0);
        check_all("R5 R9 layout");

        // ---------- Episode 3: bank full during drain (R8)
        do_reset();
        fill_bank1();
        chk(busy == 1'b0, "R3 fill without collision", busy, 0);
        send_rule(32'hFFFF_0000, 16, 77, 1'b1);
        chk(err == 1'b0, "R8 no err before drain", err, 0);
        chk(busy == 1'b1, "R6 busy on double collision", busy, 1);
        close_cfg();
        chk(err == 1'b1, "R8 full bank sets err", err, 1);
        check_all("R8 layout");

        // ---------- Episode 4: queue overflow boundary (R7)
        do_reset();
        fill_bank1();
        for (int k = 0; k < 8; k++) send_rule({16'hF000 + 16'(k), 16'h0}, 16, 100 + k, 1'b1);
        chk(err == 1'b0, "R7 eight queued rules fit", err, 0);
        send_rule(32'hF100_0000, 16, 120, 1'b1);
        chk(err == 1'b1, "R7 ninth queued rule sets err", err, 1);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy held during drain", busy, 1);
        model_drain();
        begin
            bit low;
            low = 1'b0;
            for (int k = 0; k < 6000 && !low; k++) begin
                @(negedge clk);
                if (!busy) low = 1'b1;
            end
            chk(low, "R6 busy falls after drain", busy, 0);
        end
        chk(err == 1'b1, "R7 err stays set", err, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule